// File: doc/BRIEF.md
# Strobed Serial Register-Access Slave

This block is the device end of a four-wire register bus that a host drives by toggling pins in software: a clear line, a strobe line, a host-to-device data line and a device-to-host data line. The host frames every transaction with a pulse on the clear line. It then clocks in an 8-bit command, most significant bit first, using rising edges of the strobe. The command is a read flag followed by a 7-bit register address. Sixteen data bits follow, also most significant bit first. On a write the host shifts them in. On a read the block shifts them out.

The block holds a small register file. Two identity words are fixed: a platform identity and a firmware identity. Three banks of writable control words sit beside them: function enables, GPIO enables and GPIO directions. The writable words drive output ports that feed pin and LED logic elsewhere on the chip. All three pins are asynchronous to the block. Each one passes through a two-flop synchronizer, and strobe edges are found in the system clock domain. The strobe period must be at least four system clocks.

Top module: `sreg_slave`

## Requirements
- R1: After reset, `dout_pin` is low and every function-enable, GPIO-enable and GPIO-direction word reads as zero on its output port.
- R2: When the clear line is high, any partial transfer is aborted. A write that is cut off before its 16th data bit changes no register, and the next transaction after clear decodes normally.
- R3: After clear, the first 8 strobe rising edges capture the command MSB first. Command bit 7 set to 1 means read and 0 means write. Bits 6:0 are the address.
- R4: On a write, the next 16 strobe rising edges capture data MSB first. After the 16th edge the word appears on the addressed register's output port. The address map is: function enable i at 0x08+i, GPIO enable i at 0x10+i, GPIO direction i at 0x18+i. Port slice i is bits [16*i+15:16*i].
- R5: On a read, `dout_pin` carries data bit 15 after the first data-phase strobe rising edge and the next lower bit after each following edge. Each bit is valid by the falling edge that follows.
- R6: Address 0x00 reads the platform identity, whose low byte is the manufacturer code 0x01. The default value is 0x5A01.
- R7: Address 0x01 reads the firmware identity, packed as build[15:12], major[11:8], minor[7:4] and patch[3:0]. The major field is 0. The default value is 0x3042.
- R8: Writes to address 0x00 or 0x01 are ignored, and both identities read back unchanged.
- R9: Writes to unmapped addresses are ignored and leave every output word unchanged. Reads from unmapped addresses return 0. With the defaults (2 function words, 3 GPIO words), 0x05, 0x0A and 0x7F are unmapped.
- R10: `dout_pin` changes only on a strobe rising edge or a clear. It is low outside the read data phase, including after the strobe edge that follows the 16th read bit.
- R11: Strobe edges after the 24th bit of a transaction are ignored until the next clear, and no second write takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_pin | input | 1 | Asynchronous clear line; high aborts and restarts framing |
| stb_pin | input | 1 | Asynchronous strobe; rising edge clocks a bit |
| din_pin | input | 1 | Asynchronous host-to-device serial data |
| dout_pin | output | 1 | Device-to-host serial data |
| func_en_o | output | 32 | Function-enable words, word i at [16*i+15:16*i] |
| gpio_en_o | output | 48 | GPIO-enable words |
| gpio_dir_o | output | 48 | GPIO-direction words |

## Verification
A pin change reaches the edge detector after two synchronizer flops. So `dout_pin` takes its new bit on the third system clock edge after the strobe rises on the pin. A written word appears on its output port one edge after that, four edges after the 24th rising strobe. The bench holds every strobe level for four clocks and samples outputs on the falling clock edge just before it next moves the strobe. Every read bit and register value is therefore sampled at least one clock after it is due. Read words are compared by a scoreboard against values queued when the read was issued. Register output ports are checked once each transaction has finished.

// File: rtl/sreg_pkg.sv
// Shared widths, address groups and the write-request type for the
// strobed register slave. Assumes at most 8 words per register group.
package sreg_pkg;
    localparam int DW     = 16;   // data word width
    localparam int AW     = 7;    // register address width
    localparam int CMD_W  = AW + 1;
    localparam int GRP_W  = 4;    // address bits 6:3 select a group
    localparam int IDX_W  = AW - GRP_W;

    localparam logic [GRP_W-1:0] GRP_ID   = 4'h0;
    localparam logic [GRP_W-1:0] GRP_FUNC = 4'h1;
    localparam logic [GRP_W-1:0] GRP_GEN  = 4'h2;
    localparam logic [GRP_W-1:0] GRP_GDIR = 4'h3;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    // Build a register address from a group and an index inside it
    function automatic logic [AW-1:0] reg_addr(input logic [GRP_W-1:0] grp, input int idx);
        return {grp, IDX_W'(idx)};
    endfunction
endpackage

// File: rtl/sreg_sync.sv
// Two-flop synchronizer for a bundle of independent asynchronous bits.
// Assumes each bit is only sampled as a level; no bus coherence is implied.
module sreg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage capture into the system clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/sreg_frame.sv
// Transaction framer: counts strobe rising edges after a clear, assembles
// the command, shifts write data in or read data out, and issues one write
// request after the last write bit. Assumes synchronized inputs and a
// strobe period of at least four clocks.
module sreg_frame
    import sreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_s,
    input  logic          stb_s,
    input  logic          din_s,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output wr_req_t       wr_o,
    output logic          dout_o
);
    localparam int TOTAL = CMD_W + DW;
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOTAL);

    logic             stb_q;
    logic             stb_rise;
    logic [CNT_W-1:0] cnt_q;
    logic [CMD_W-1:0] cmd_q;
    logic [DW-1:0]    wsh_q;
    logic [DW-1:0]    rsh_q;
    logic             is_rd;

    assign stb_rise  = stb_s & ~stb_q;
    assign is_rd     = cmd_q[CMD_W-1];
    assign rd_addr_o = cmd_q[AW-1:0];

    // Framing state machine advanced by strobe rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            cnt_q  <= '0;
            cmd_q  <= '0;
            wsh_q  <= '0;
            rsh_q  <= '0;
            dout_o <= 1'b0;
            wr_o   <= '0;
        end else begin
            stb_q   <= stb_s;
            wr_o.en <= 1'b0;
            if (clr_s) begin
                cnt_q  <= '0;
                cmd_q  <= '0;
                dout_o <= 1'b0;
            end else if (stb_rise) begin
                if (cnt_q < CNT_CMD) begin
                    cmd_q <= {cmd_q[CMD_W-2:0], din_s};
                    cnt_q <= cnt_q + 1'b1;
                end else if (cnt_q < CNT_LAST) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (is_rd) begin
                        if (cnt_q == CNT_CMD) begin
                            dout_o <= rd_data_i[DW-1];
                            rsh_q  <= {rd_data_i[DW-2:0], 1'b0};
                        end else begin
                            dout_o <= rsh_q[DW-1];
                            rsh_q  <= {rsh_q[DW-2:0], 1'b0};
                        end
                    end else begin
                        wsh_q <= {wsh_q[DW-2:0], din_s};
                        if (cnt_q == CNT_LAST - 1'b1) begin
                            wr_o.en   <= 1'b1;
                            wr_o.addr <= cmd_q[AW-1:0];
                            wr_o.data <= {wsh_q[DW-2:0], din_s};
                        end
                    end
                end else begin
                    dout_o <= 1'b0;
                end
            end
        end
    end

    // R2: a clear leaves the output idle and issues no write
    a_r2_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> (!dout_o && !wr_o.en));
    // R10: the serial output only moves on a strobe edge or a clear
    a_r10_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_rise && !clr_s) |=> $stable(dout_o));
    // R4: a write request is a single-cycle pulse
    a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o.en |=> !wr_o.en);
    // R11: a write request only follows a strobe edge
    a_r11_wr_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o.en |-> $past(stb_rise));
endmodule

// File: rtl/sreg_regfile.sv
// Register file: two fixed identity words plus three banks of writable
// control words. Writes to identity or unmapped addresses are dropped;
// unmapped reads return zero. Assumes N_FUNC and N_GPIO are at most 8.
module sreg_regfile
    import sreg_pkg::*;
#(
    parameter int            N_FUNC  = 2,
    parameter int            N_GPIO  = 3,
    parameter logic [DW-1:0] PLAT_ID = 16'h5A01,
    parameter logic [DW-1:0] FW_ID   = 16'h3042
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wr_req_t            wr_i,
    input  logic [AW-1:0]      rd_addr_i,
    output logic [DW-1:0]      rd_data_o,
    output logic [N_FUNC*DW-1:0] func_o,
    output logic [N_GPIO*DW-1:0] gen_o,
    output logic [N_GPIO*DW-1:0] gdir_o
);
    logic [DW-1:0] func_q [N_FUNC];
    logic [DW-1:0] gen_q  [N_GPIO];
    logic [DW-1:0] gdir_q [N_GPIO];
    logic          wr_map;

    for (genvar i = 0; i < N_FUNC; i++) begin : g_func
        localparam logic [AW-1:0] ADDR = reg_addr(GRP_FUNC, i);
        // Function-enable word i storage
        always_ff @(posedge clk) begin
            if (!rst_n)                         func_q[i] <= '0;
            else if (wr_i.en && wr_i.addr == ADDR) func_q[i] <= wr_i.data;
        end
        assign func_o[i*DW +: DW] = func_q[i];
    end

    for (genvar i = 0; i < N_GPIO; i++) begin : g_gpio
        localparam logic [AW-1:0] A_EN  = reg_addr(GRP_GEN, i);
        localparam logic [AW-1:0] A_DIR = reg_addr(GRP_GDIR, i);
        // GPIO enable and direction word i storage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gen_q[i]  <= '0;
                gdir_q[i] <= '0;
            end else if (wr_i.en) begin
                if (wr_i.addr == A_EN)  gen_q[i]  <= wr_i.data;
                if (wr_i.addr == A_DIR) gdir_q[i] <= wr_i.data;
            end
        end
        assign gen_o[i*DW +: DW]  = gen_q[i];
        assign gdir_o[i*DW +: DW] = gdir_q[i];
    end

    // Read mux; anything unmatched returns zero
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == reg_addr(GRP_ID, 0)) rd_data_o = PLAT_ID;
        if (rd_addr_i == reg_addr(GRP_ID, 1)) rd_data_o = FW_ID;
        for (int i = 0; i < N_FUNC; i++)
            if (rd_addr_i == reg_addr(GRP_FUNC, i)) rd_data_o = func_q[i];
        for (int i = 0; i < N_GPIO; i++) begin
            if (rd_addr_i == reg_addr(GRP_GEN, i))  rd_data_o = gen_q[i];
            if (rd_addr_i == reg_addr(GRP_GDIR, i)) rd_data_o = gdir_q[i];
        end
    end

    // Whether the write address hits any writable word
    always_comb begin
        wr_map = 1'b0;
        for (int i = 0; i < N_FUNC; i++)
            if (wr_i.addr == reg_addr(GRP_FUNC, i)) wr_map = 1'b1;
        for (int i = 0; i < N_GPIO; i++)
            if (wr_i.addr == reg_addr(GRP_GEN, i) || wr_i.addr == reg_addr(GRP_GDIR, i))
                wr_map = 1'b1;
    end

    // R9: writes that hit nothing leave every control word alone
    a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i.en && !wr_map) |=> ($stable(func_o) && $stable(gen_o) && $stable(gdir_o)));
    // R8: writes into the identity group change no control word
    a_r8_id_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i.en && wr_i.addr[AW-1:IDX_W] == GRP_ID) |=>
        ($stable(func_o) && $stable(gen_o) && $stable(gdir_o)));
    // R4: a write to function word 0 lands on its port next cycle
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i.en && wr_i.addr == reg_addr(GRP_FUNC, 0)) |=> (func_o[DW-1:0] == $past(wr_i.data)));
endmodule

// File: rtl/sreg_slave.sv
// Top of the strobed serial register slave: synchronizes the three host
// pins, frames transactions and serves the register file. Assumes the host
// holds each strobe level for at least two system clocks.
module sreg_slave
    import sreg_pkg::*;
#(
    parameter int            N_FUNC  = 2,
    parameter int            N_GPIO  = 3,
    parameter logic [15:0]   PLAT_ID = 16'h5A01,
    parameter logic [15:0]   FW_ID   = 16'h3042
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_pin,
    input  logic                 stb_pin,
    input  logic                 din_pin,
    output logic                 dout_pin,
    output logic [N_FUNC*16-1:0] func_en_o,
    output logic [N_GPIO*16-1:0] gpio_en_o,
    output logic [N_GPIO*16-1:0] gpio_dir_o
);
    logic [2:0]    pins_s;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    wr_req_t       wr_req;

    sreg_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({clr_pin, stb_pin, din_pin}),
        .q     (pins_s)
    );

    sreg_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_s     (pins_s[2]),
        .stb_s     (pins_s[1]),
        .din_s     (pins_s[0]),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_o      (wr_req),
        .dout_o    (dout_pin)
    );

    sreg_regfile #(
        .N_FUNC  (N_FUNC),
        .N_GPIO  (N_GPIO),
        .PLAT_ID (PLAT_ID),
        .FW_ID   (FW_ID)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_req),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .func_o    (func_en_o),
        .gen_o     (gpio_en_o),
        .gdir_o    (gpio_dir_o)
    );
endmodule

// File: tb/sreg_slave_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares
// them with the words captured from the serial output.
module sreg_slave_tb;
    localparam int HP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_pin = 1'b0;
    logic        stb_pin = 1'b1;
    logic        din_pin = 1'b0;
    logic        dout_pin;
    logic [31:0] func_en_o;
    logic [47:0] gpio_en_o;
    logic [47:0] gpio_dir_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] exp_q[$];
    logic [15:0] got_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    sreg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .clr_pin(clr_pin), .stb_pin(stb_pin),
        .din_pin(din_pin), .dout_pin(dout_pin), .func_en_o(func_en_o),
        .gpio_en_o(gpio_en_o), .gpio_dir_o(gpio_dir_o)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic host_clear();
        clr_pin = 1'b1; wt(HP);
        clr_pin = 1'b0; wt(HP);
    endtask

    task automatic send_cmd(input bit rd, input logic [6:0] a);
        logic [7:0] c;
        c = {rd, a};
        host_clear();
        for (int i = 7; i >= 0; i--) begin
            stb_pin = 1'b0; din_pin = c[i]; wt(HP);
            stb_pin = 1'b1; wt(HP);
        end
        stb_pin = 1'b0; din_pin = 1'b0; wt(HP);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] w);
        send_cmd(1'b0, a);
        for (int i = 15; i >= 0; i--) begin
            din_pin = w[i]; wt(1);
            stb_pin = 1'b1; wt(HP);
            stb_pin = 1'b0; wt(HP - 1);
        end
        stb_pin = 1'b1; wt(HP);
        chk("R10 dout idle after write", 64'(dout_pin), 64'd0);
    endtask

    task automatic do_read(input logic [6:0] a, input logic [15:0] e, input string tag);
        logic [15:0] r;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        send_cmd(1'b1, a);
        r = '0;
        for (int i = 15; i >= 0; i--) begin
            stb_pin = 1'b1; wt(HP);
            stb_pin = 1'b0; wt(HP);
            r[i] = dout_pin;
        end
        stb_pin = 1'b1; wt(HP);
        got_q.push_back(r);
        chk("R10 dout idle after read", 64'(dout_pin), 64'd0);
    endtask

    // Monitor: pair captured read words with queued expectations
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [15:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 64'(g), 64'(e));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wt(5);
        // R1: reset state
        chk("R1 dout after reset", 64'(dout_pin), 64'd0);
        chk("R1 func after reset", 64'(func_en_o), 64'd0);
        chk("R1 gpio en after reset", 64'(gpio_en_o), 64'd0);
        chk("R1 gpio dir after reset", 64'(gpio_dir_o), 64'd0);
        rst_n = 1'b1; wt(HP);

        // R6, R7, R5: identity reads
        do_read(7'h00, 16'h5A01, "R6 platform id");
        do_read(7'h01, 16'h3042, "R7 firmware id");

        // R3, R4, R5: writes land on ports and read back MSB first
        do_write(7'h08, 16'hBEEF);
        chk("R4 func0 port", 64'(func_en_o), 64'h0000_BEEF);
        do_read(7'h08, 16'hBEEF, "R5 func0 readback");
        do_write(7'h1A, 16'h8001);
        chk("R4 gdir2 port", 64'(gpio_dir_o), 64'h8001_0000_0000);
        do_read(7'h1A, 16'h8001, "R5 gdir2 readback");
        do_write(7'h11, 16'h00FF);
        chk("R3 gen1 port", 64'(gpio_en_o), 64'h0000_00FF_0000);
        do_read(7'h11, 16'h00FF, "R3 gen1 readback");

        // R8: identity words ignore writes
        do_write(7'h00, 16'h0000);
        do_write(7'h01, 16'hFFFF);
        do_read(7'h00, 16'h5A01, "R8 platform id unchanged");
        do_read(7'h01, 16'h3042, "R8 firmware id unchanged");
        chk("R8 func unchanged", 64'(func_en_o), 64'h0000_BEEF);

        // R9: unmapped writes ignored, unmapped reads zero
        do_write(7'h05, 16'h1234);
        do_write(7'h0A, 16'h1234);
        chk("R9 func unchanged", 64'(func_en_o), 64'h0000_BEEF);
        chk("R9 gen unchanged", 64'(gpio_en_o), 64'h0000_00FF_0000);
        chk("R9 gdir unchanged", 64'(gpio_dir_o), 64'h8001_0000_0000);
        do_read(7'h0A, 16'h0000, "R9 unmapped read 0x0A");
        do_read(7'h7F, 16'h0000, "R9 unmapped read 0x7F");

        // R2: clear in mid data phase aborts the write
        send_cmd(1'b0, 7'h09);
        for (int i = 0; i < 8; i++) begin
            din_pin = 1'b1; wt(1);
            stb_pin = 1'b1; wt(HP);
            stb_pin = 1'b0; wt(HP - 1);
        end
        host_clear();
        wt(HP);
        chk("R2 aborted write", 64'(func_en_o), 64'h0000_BEEF);
        // R2: clear in mid command, then a clean write
        for (int i = 0; i < 3; i++) begin
            stb_pin = 1'b0; din_pin = 1'b1; wt(HP);
            stb_pin = 1'b1; wt(HP);
        end
        do_write(7'h09, 16'h5555);
        chk("R2 write after abort", 64'(func_en_o), 64'h5555_BEEF);

        // R11: extra strobes after the frame do nothing
        do_write(7'h10, 16'h1111);
        for (int i = 0; i < 16; i++) begin
            stb_pin = 1'b0; din_pin = 1'b1; wt(HP);
            stb_pin = 1'b1; wt(HP);
        end
        chk("R11 gen0 after extra strobes", 64'(gpio_en_o), 64'h0000_00FF_1111);
        chk("R11 dout idle", 64'(dout_pin), 64'd0);

        wt(10);
        chk("scoreboard drained", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule